// File: doc/BRIEF.md
# Debug Status Byte Serializer

This block measures a video pipeline's health and streams the results to a host as a fixed record of 13 bytes. It counts input and output frame-start strobes in one-second windows to give frame rates. It times the frame-write and frame-processing busy intervals in whole milliseconds. It also counts how many frames are dropped between successive completed processing passes. Alongside these measurements it carries the device state code, the source resolution and the frame byte count, which are taken straight from its inputs.

A host-side consumer asks for a record with a one-cycle send request. At that moment the block copies every field into a snapshot, so the record reflects a single instant. The record then leaves one byte per valid/ready handshake. One stream is meant to feed a UART transmitter and a USB serial endpoint in parallel, so that every byte reaches both.

Top module: `dbg_status_streamer`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is low. Until new events are observed, a record reports zero in every measured byte (indices 5 to 9).
- R2: A send_req sampled while no record is in progress starts a record. Byte index 0 is valid in the cycle after the request. Exactly 13 bytes follow, and out_last is high with index 12 only.
- R3: Byte layout by index: 0 holds the device state. 1 to 4 hold the resolution, least significant byte first. 5 holds the input rate and 6 the output rate. 7 holds the write time and 8 the processing time. 9 holds the dropped count. 10 to 12 hold the frame byte count, least significant byte first.
- R4: A byte stays on out_data, unchanged, until a cycle with out_ready high. The block advances by exactly one byte per handshake.
- R5: All fields are captured when the record starts. Input changes during the record do not alter its bytes.
- R6: A send_req during a record is ignored: no extra bytes appear, and out_valid falls in the cycle after the last handshake.
- R7: Each rate byte reports the number of strobes seen in the last completed window of CLK_HZ cycles. The value holds until the next window ends and saturates at 255.
- R8: A busy timer reports the number of millisecond ticks (one every CLK_HZ/1000 cycles) that occurred while the flag was high. It updates when the flag falls, and a flag held high for N ms reports N.
- R9: A millisecond byte saturates at 255 instead of wrapping.
- R10: The dropped byte reports the drop strobes counted since the previous fall of the processing flag. It updates at each such fall and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Request to emit one record |
| dev_state | input | 8 | Device state code |
| src_res | input | 32 | Source resolution word |
| in_frame_stb | input | 1 | Input-path frame-start strobe |
| out_frame_stb | input | 1 | Output-path frame-start strobe |
| wr_busy | input | 1 | High while a frame is being written |
| proc_busy | input | 1 | High while a frame is being processed |
| drop_stb | input | 1 | One pulse per dropped frame |
| frame_bytes | input | 24 | Byte count of one frame |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | A record byte is on out_data |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Current byte is the final record byte |

## Verification
The bench builds the block with CLK_HZ set to 4000. This makes a millisecond four cycles long and a rate window 4000 cycles long. At that setting three full rate windows, a 300-strobe saturation burst and a 1200-cycle busy interval that overruns 255 ms all fit in a short run. Records are drained under always-ready, alternating and one-in-three ready patterns, so the byte order is checked under back-pressure.

// File: rtl/dbgs_pkg.sv
package dbgs_pkg;

    localparam int REC_LEN  = 13;
    localparam int IDX_W    = $clog2(REC_LEN);
    localparam int RES_W    = 32;
    localparam int FBYTES_W = 24;
    localparam int MEAS_W   = 8;
    localparam int N_RATE   = 2;   // 0: input path, 1: output path
    localparam int N_TIMER  = 2;   // 0: write, 1: processing
    localparam int MS_PER_S = 1000;

    typedef logic [MEAS_W-1:0] meas_t;

    typedef struct packed {
        logic [7:0]          dev_state;
        logic [RES_W-1:0]    src_res;
        meas_t               fps_in;
        meas_t               fps_out;
        meas_t               wr_ms;
        meas_t               proc_ms;
        meas_t               drops;
        logic [FBYTES_W-1:0] frame_bytes;
    } status_rec_t;

    typedef enum logic {SER_IDLE, SER_SEND} ser_state_t;

    function automatic meas_t sat_inc(input meas_t v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

    function automatic logic [7:0] rec_byte(input status_rec_t r, input logic [IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = r.dev_state;
            4'd1:    b = r.src_res[7:0];
            4'd2:    b = r.src_res[15:8];
            4'd3:    b = r.src_res[23:16];
            4'd4:    b = r.src_res[31:24];
            4'd5:    b = r.fps_in;
            4'd6:    b = r.fps_out;
            4'd7:    b = r.wr_ms;
            4'd8:    b = r.proc_ms;
            4'd9:    b = r.drops;
            4'd10:   b = r.frame_bytes[7:0];
            4'd11:   b = r.frame_bytes[15:8];
            4'd12:   b = r.frame_bytes[23:16];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dbgs_tick_gen.sv
module dbgs_tick_gen #(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic ms_tick,
    output logic sec_tick
);
    import dbgs_pkg::*;

    localparam int unsigned CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int MSC_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int SEC_W = $clog2(MS_PER_S);

    logic [MSC_W-1:0] ms_cnt;
    logic [SEC_W-1:0] sec_cnt;

    assign ms_tick  = (ms_cnt == MSC_W'(CYC_PER_MS - 1));
    assign sec_tick = ms_tick && (sec_cnt == SEC_W'(MS_PER_S - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else begin
            if (ms_tick) begin
                ms_cnt <= '0;
                if (sec_tick) sec_cnt <= '0;
                else          sec_cnt <= sec_cnt + 1'b1;
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbgs_rate_meter.sv
module dbgs_rate_meter (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic             strobe,
    output dbgs_pkg::meas_t  rate
);
    import dbgs_pkg::*;

    meas_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            rate <= '0;
        end else if (sec_tick) begin
            rate <= strobe ? sat_inc(cnt) : cnt;
            cnt  <= '0;
        end else if (strobe) begin
            cnt <= sat_inc(cnt);
        end
    end
endmodule

// File: rtl/dbgs_busy_timer.sv
module dbgs_busy_timer (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             busy,
    output logic             done,
    output dbgs_pkg::meas_t  ms_out
);
    import dbgs_pkg::*;

    logic  busy_q;
    meas_t cnt;

    assign done = busy_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
            ms_out <= '0;
        end else begin
            busy_q <= busy;
            if (!busy)        cnt <= '0;
            else if (ms_tick) cnt <= sat_inc(cnt);
            if (done)         ms_out <= cnt;
        end
    end
endmodule

// File: rtl/dbgs_drop_ratio.sv
module dbgs_drop_ratio (
    input  logic             clk,
    input  logic             rst,
    input  logic             drop_stb,
    input  logic             proc_done,
    output dbgs_pkg::meas_t  ratio
);
    import dbgs_pkg::*;

    meas_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ratio <= '0;
        end else if (proc_done) begin
            ratio <= drop_stb ? sat_inc(cnt) : cnt;
            cnt   <= '0;
        end else if (drop_stb) begin
            cnt <= sat_inc(cnt);
        end
    end
endmodule

// File: rtl/dbgs_serializer.sv
module dbgs_serializer (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  send_req,
    input  dbgs_pkg::status_rec_t live,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    output logic                  out_last
);
    import dbgs_pkg::*;

    ser_state_t            st;
    status_rec_t           snap;
    logic [IDX_W-1:0]      idx;

    assign out_valid = (st == SER_SEND);
    assign out_last  = out_valid && (idx == IDX_W'(REC_LEN - 1));
    assign out_data  = out_valid ? rec_byte(snap, idx) : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SER_IDLE;
            idx  <= '0;
            snap <= '0;
        end else begin
            case (st)
                SER_IDLE: if (send_req) begin
                    snap <= live;
                    idx  <= '0;
                    st   <= SER_SEND;
                end
                SER_SEND: if (out_ready) begin
                    if (out_last) st  <= SER_IDLE;
                    else          idx <= idx + 1'b1;
                end
                default: st <= SER_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbg_status_streamer.sv
module dbg_status_streamer #(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        send_req,
    input  logic [7:0]  dev_state,
    input  logic [31:0] src_res,
    input  logic        in_frame_stb,
    input  logic        out_frame_stb,
    input  logic        wr_busy,
    input  logic        proc_busy,
    input  logic        drop_stb,
    input  logic [23:0] frame_bytes,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last
);
    import dbgs_pkg::*;

    logic ms_tick, sec_tick;
    logic  [N_RATE-1:0]  rate_stb;
    meas_t               rate_val  [N_RATE];
    logic  [N_TIMER-1:0] busy_flag;
    logic  [N_TIMER-1:0] busy_done;
    meas_t               busy_ms   [N_TIMER];
    meas_t               drop_val;
    status_rec_t         live;

    dbgs_tick_gen #(.CLK_HZ(CLK_HZ)) u_ticks (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .sec_tick(sec_tick)
    );

    assign rate_stb  = {out_frame_stb, in_frame_stb};
    assign busy_flag = {proc_busy, wr_busy};

    for (genvar g = 0; g < N_RATE; g++) begin : g_rate
        dbgs_rate_meter u_rate (
            .clk(clk), .rst(rst), .sec_tick(sec_tick),
            .strobe(rate_stb[g]), .rate(rate_val[g])
        );
    end

    for (genvar g = 0; g < N_TIMER; g++) begin : g_timer
        dbgs_busy_timer u_tmr (
            .clk(clk), .rst(rst), .ms_tick(ms_tick), .busy(busy_flag[g]),
            .done(busy_done[g]), .ms_out(busy_ms[g])
        );
    end

    dbgs_drop_ratio u_drop (
        .clk(clk), .rst(rst), .drop_stb(drop_stb),
        .proc_done(busy_done[1]), .ratio(drop_val)
    );

    always_comb begin
        live.dev_state   = dev_state;
        live.src_res     = src_res;
        live.fps_in      = rate_val[0];
        live.fps_out     = rate_val[1];
        live.wr_ms       = busy_ms[0];
        live.proc_ms     = busy_ms[1];
        live.drops       = drop_val;
        live.frame_bytes = frame_bytes;
    end

    dbgs_serializer u_ser (
        .clk(clk), .rst(rst), .send_req(send_req), .live(live),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );
endmodule

// File: rtl/dbgs_checker.sv
module dbgs_checker (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last
);
    import dbgs_pkg::*;

    logic       rst_d;
    logic [4:0] hs_cnt;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst || !out_valid)       hs_cnt <= '0;
        else if (out_ready)          hs_cnt <= hs_cnt + 1'b1;
    end

    // R1: no byte offered right after reset
    always @(negedge clk) begin
        if (rst_d === 1'b1) a_r1_idle_after_reset: assert (out_valid == 1'b0);
    end

    a_r2_last_only_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r2_record_length: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (hs_cnt == 5'(REC_LEN - 1)));

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    a_r6_end_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind dbg_status_streamer dbgs_checker u_dbgs_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
);

// File: tb/dbg_status_streamer_bench.sv
module dbg_status_streamer_bench;

    localparam int unsigned C = 4000;   // cycles per rate window

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        send_req = 1'b0;
    logic [7:0]  dev_state = '0;
    logic [31:0] src_res = '0;
    logic        in_frame_stb = 1'b0, out_frame_stb = 1'b0;
    logic        wr_busy = 1'b0, proc_busy = 1'b0, drop_stb = 1'b0;
    logic [23:0] frame_bytes = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_last;
    logic [7:0]  out_data;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic [7:0] got [13];
    logic [7:0] expb [13];
    int got_n, last_pos, last_cnt;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    dbg_status_streamer #(.CLK_HZ(C)) u_dbg_status_streamer (
        .clk(clk), .rst(rst), .send_req(send_req), .dev_state(dev_state),
        .src_res(src_res), .in_frame_stb(in_frame_stb), .out_frame_stb(out_frame_stb),
        .wr_busy(wr_busy), .proc_busy(proc_busy), .drop_stb(drop_stb),
        .frame_bytes(frame_bytes), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    typedef struct packed {
        logic [7:0]  st;
        logic [31:0] res;
        logic [23:0] fb;
        logic [1:0]  mode;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'h01, 32'h0500_02D0, 24'h0A8C00, 2'd0},
        '{8'h7E, 32'h0780_0438, 24'h17BB00, 2'd1},
        '{8'hFF, 32'hDEAD_BEEF, 24'hFFFFFF, 2'd2},
        '{8'h00, 32'h0000_0001, 24'h000001, 2'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [7:0] st, input logic [31:0] res,
                             input logic [7:0] fin, input logic [7:0] fout,
                             input logic [7:0] wr, input logic [7:0] pr,
                             input logic [7:0] dr, input logic [23:0] fb);
        expb[0] = st;
        for (int i = 0; i < 4; i++) expb[1+i] = res[8*i +: 8];
        expb[5] = fin; expb[6] = fout; expb[7] = wr; expb[8] = pr; expb[9] = dr;
        for (int i = 0; i < 3; i++) expb[10+i] = fb[8*i +: 8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // mode 0: always ready, 1: alternating, 2: one cycle in three
    task automatic collect(input int mode, input bit mutate, input bit extra_req);
        got_n = 0; last_pos = -1; last_cnt = 0;
        @(negedge clk);
        send_req = 1'b1;
        @(negedge clk);
        send_req = 1'b0;
        for (int k = 0; k < 400 && got_n < 13; k++) begin
            case (mode)
                0:       out_ready = 1'b1;
                1:       out_ready = (k % 2) == 1;
                default: out_ready = (k % 3) == 2;
            endcase
            send_req = extra_req && (k == 4 || k == 9);
            if (mutate && k == 2) begin
                dev_state = ~dev_state;
                src_res   = ~src_res;
                frame_bytes = ~frame_bytes;
            end
            #1;
            if (k == 0) chk(out_valid === 1'b1, "R2 first byte valid", int'(out_valid), 1);
            if (out_valid && out_ready) begin
                got[got_n] = out_data;
                if (out_last) begin last_pos = got_n; last_cnt++; end
                got_n++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        send_req  = 1'b0;
        chk(got_n == 13, "R2 byte count", got_n, 13);
        chk(last_cnt == 1 && last_pos == 12, "R2 last marker position", last_pos, 12);
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(out_valid === 1'b0, "R6 idle after record", int'(out_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic compare(input string req);
        for (int i = 0; i < 13; i++)
            chk(got[i] === expb[i], $sformatf("%s byte %0d", req, i), int'(got[i]), int'(expb[i]));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk(out_valid === 1'b0, "R1 reset idle", int'(out_valid), 0);

        // Table walk: R3 layout and R4 back-pressure, measured bytes zero (R1)
        for (int v = 0; v < 4; v++) begin
            dev_state = VECS[v].st; src_res = VECS[v].res; frame_bytes = VECS[v].fb;
            collect(int'(VECS[v].mode), 1'b0, 1'b0);
            build_exp(VECS[v].st, VECS[v].res, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, VECS[v].fb);
            compare($sformatf("R3 R4 R1 vec%0d", v));
        end

        // R7: rates in window 1
        do_reset();
        dev_state = 8'h42; src_res = 32'h1122_3344; frame_bytes = 24'h556677;
        wait_cyc(1000);
        for (int i = 0; i < 30; i++) begin
            in_frame_stb = 1'b1; out_frame_stb = (i < 25);
            @(negedge clk);
            in_frame_stb = 1'b0; out_frame_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
        wait_cyc(5000);
        collect(0, 1'b0, 1'b0);
        build_exp(8'h42, 32'h1122_3344, 8'd30, 8'd25, 8'd0, 8'd0, 8'd0, 24'h556677);
        compare("R7 window rates");

        // window 2: rate saturation (R7), timers (R8, R9), drops (R10)
        wait_cyc(5100);
        for (int i = 0; i < 300; i++) begin
            in_frame_stb = 1'b1;
            @(negedge clk);
            in_frame_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
        wr_busy = 1'b1;
        repeat (24) @(negedge clk);
        wr_busy = 1'b0;
        repeat (4) @(negedge clk);
        proc_busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            drop_stb = 1'b1; @(negedge clk); drop_stb = 1'b0; @(negedge clk);
        end
        repeat (1194) @(negedge clk);
        proc_busy = 1'b0;
        wait_cyc(9000);
        collect(1, 1'b0, 1'b0);
        build_exp(8'h42, 32'h1122_3344, 8'd255, 8'd0, 8'd6, 8'd255, 8'd3, 24'h556677);
        compare("R7 R8 R9 R10 saturation and timing");

        // window 3: empty; short processing pass with no drops
        proc_busy = 1'b1;
        repeat (8) @(negedge clk);
        proc_busy = 1'b0;
        wait_cyc(13000);
        collect(2, 1'b0, 1'b0);
        build_exp(8'h42, 32'h1122_3344, 8'd0, 8'd0, 8'd6, 8'd2, 8'd0, 24'h556677);
        compare("R7 R8 R10 window clear and hold");

        // R5 snapshot and R6 ignored request
        collect(2, 1'b1, 1'b1);
        compare("R5 R6 snapshot");
        collect(0, 1'b0, 1'b0);
        chk(got[0] === 8'hBD, "R5 new snapshot byte0", int'(got[0]), 'hBD);
        chk(got[1] === 8'hBB, "R5 new snapshot byte1", int'(got[1]), 'hBB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule